// File: doc/BRIEF.md
# DDR SDRAM Device-Side Command Decoder

This block sits on the device side of a four-bank DDR SDRAM command bus. At each rising clock edge it samples the chip select, the three command strobes, the bank address, the address bus, the clock enable and the per-byte data mask. It turns what it samples into a decoded command code. It keeps a per-bank record of which banks have a row open. It also holds the base and extended mode registers and follows the device's power state.

The outputs drive the rest of a memory model or a protocol monitor. These outputs are the command, the target bank, the row and column, the auto-precharge flag, the open-bank mask, the power state, per-byte write enables and two one-cycle error flags. All outputs are registered, with one exception. The power-state output leaves self refresh as soon as the clock enable goes high, without waiting for a clock edge.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: When `cs_n` is sampled high, `cmd_o` is NOP (0) in the following cycle, and neither the open-bank mask nor the mode registers change.
- R2: With `cs_n` low, `cke` high and the device awake, `{ras_n,cas_n,we_n}` is decoded as follows, and the code appears on `cmd_o` one cycle after the sampling edge:
  - 000 gives LOAD MODE (1).
  - 001 gives AUTO REFRESH (2).
  - 010 gives PRECHARGE (4).
  - 011 gives ACTIVE (5).
  - 100 gives WRITE (6).
  - 101 gives READ (7).
  - 110 gives BURST STOP (8).
  - 111 gives NOP (0).
- R3: ACTIVE sets bit `ba` of `open_mask_o`. It also loads `row_o` with the address bus and `bank_o` with `ba`.
- R4: READ and WRITE load `col_o` with `addr[COL_W-1:0]` and drive `auto_pre_o` with `addr[10]` for one cycle. When `addr[10]` is high, bit `ba` of `open_mask_o` is cleared.
- R5: PRECHARGE with `addr[10]` low clears only bit `ba` of `open_mask_o`. With `addr[10]` high it clears every bit.
- R6: LOAD MODE with `ba`=0 writes the address bus into `mode_reg_o`, and with `ba`=1 into `ext_mode_reg_o`. With `ba`=2 or 3 it changes neither register.
- R7: When `cke` is sampled low while awake and the command is not self refresh, `pwr_state_o` becomes one of two states in the next cycle:
  - precharge power-down (1) if no bank is open;
  - active power-down (2) if any bank is open.
- R8: The pattern 001 with `cs_n` low and `cke` sampled low gives SELF REFRESH (3) on `cmd_o` and puts `pwr_state_o` into self refresh (3).
- R9: From either power-down state, `cke` sampled high at an edge returns `pwr_state_o` to awake (0) in the next cycle. From self refresh, `pwr_state_o` reads 0 as soon as `cke` is high, with no clock edge needed.
- R10: While the device is not awake, every command is ignored. `cmd_o` stays NOP and `open_mask_o` is unchanged, including at the exit edge.
- R11: On WRITE, `wr_en_o` equals the inverted data mask, so a mask bit of 1 blocks its byte lane. On READ and on every other command, `wr_en_o` is all zero.
- R12: ACTIVE to a bank whose bit is already set in `open_mask_o` raises `act_err_o` for exactly one cycle. The bank stays open.
- R13: READ or WRITE sampled with `cke` low raises `proto_err_o` for one cycle. The access is not executed (`cmd_o` is NOP) and the device enters power-down as in R7.
- R14: After reset, all of the following hold:
  - `cmd_o`, `open_mask_o`, `pwr_state_o`, both mode registers, `wr_en_o` and both error flags are zero;
  - `row_o`, `col_o`, `bank_o` and `auto_pre_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank address / mode register select |
| addr | input | ADDR_W | Row, column or op-code; bit 10 is the per-command flag |
| dm | input | LANES | Data mask, one bit per byte lane |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | BANK_W | Target bank of the last bank command |
| row_o | output | ADDR_W | Row of the last ACTIVE |
| col_o | output | COL_W | Column of the last READ/WRITE |
| auto_pre_o | output | 1 | Auto-precharge flag of the current READ/WRITE |
| open_mask_o | output | 2**BANK_W | One bit per bank with an open row |
| pwr_state_o | output | 2 | 0 awake, 1 precharge power-down, 2 active power-down, 3 self refresh |
| wr_en_o | output | LANES | Per-lane write enable for the current WRITE |
| mode_reg_o | output | ADDR_W | Base mode register |
| ext_mode_reg_o | output | ADDR_W | Extended mode register |
| act_err_o | output | 1 | ACTIVE to an already open bank |
| proto_err_o | output | 1 | READ/WRITE with clock enable low |

## Verification
Every result except the self-refresh release is due on the first rising edge after the edge that sampled the command. The bench drives inputs on falling edges and compares outputs on the following falling edge, so exactly one register stage is counted. The self-refresh release of R9 is combinational. The bench therefore raises `cke` just after a falling edge and compares `pwr_state_o` a moment later, before any rising edge arrives. The bench then confirms that the registered state agrees after the next edge. Error flags and `auto_pre_o` are single-cycle pulses. The bench checks each of them once in the cycle it is due and again one cycle later, to see it has dropped.

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder #(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10,
  parameter int BANK_W = 2,
  parameter int LANES  = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BANK_W-1:0]      ba,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [LANES-1:0]       dm,
  output logic [3:0]             cmd_o,
  output logic [BANK_W-1:0]      bank_o,
  output logic [ADDR_W-1:0]      row_o,
  output logic [COL_W-1:0]       col_o,
  output logic                   auto_pre_o,
  output logic [(1<<BANK_W)-1:0] open_mask_o,
  output logic [1:0]             pwr_state_o,
  output logic [LANES-1:0]       wr_en_o,
  output logic [ADDR_W-1:0]      mode_reg_o,
  output logic [ADDR_W-1:0]      ext_mode_reg_o,
  output logic                   act_err_o,
  output logic                   proto_err_o
);

  localparam int NBANK = 1 << BANK_W;

  localparam logic [3:0] C_NOP  = 4'd0;
  localparam logic [3:0] C_MRS  = 4'd1;
  localparam logic [3:0] C_REF  = 4'd2;
  localparam logic [3:0] C_SREF = 4'd3;
  localparam logic [3:0] C_PRE  = 4'd4;
  localparam logic [3:0] C_ACT  = 4'd5;
  localparam logic [3:0] C_WR   = 4'd6;
  localparam logic [3:0] C_RD   = 4'd7;
  localparam logic [3:0] C_BST  = 4'd8;

  localparam logic [1:0] P_AWAKE = 2'd0;
  localparam logic [1:0] P_PPD   = 2'd1;
  localparam logic [1:0] P_APD   = 2'd2;
  localparam logic [1:0] P_SR    = 2'd3;

  logic [1:0]       st_q, st_d;
  logic [NBANK-1:0] open_q, open_d;
  logic [3:0]       dec, exec;
  logic             awake, flag10, proto_d, act_err_d;

  assign awake  = (st_q == P_AWAKE);
  assign flag10 = addr[10];

  always_comb begin
    dec = C_NOP;
    if (awake && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000:  dec = C_MRS;
        3'b001:  dec = cke ? C_REF : C_SREF;
        3'b010:  dec = C_PRE;
        3'b011:  dec = C_ACT;
        3'b100:  dec = C_WR;
        3'b101:  dec = C_RD;
        3'b110:  dec = C_BST;
        default: dec = C_NOP;
      endcase
    end
  end

  assign exec    = (cke || dec == C_SREF) ? dec : C_NOP;
  assign proto_d = !cke && (dec == C_RD || dec == C_WR);
  assign act_err_d = (exec == C_ACT) && open_q[ba];

  always_comb begin
    open_d = open_q;
    case (exec)
      C_ACT: open_d[ba] = 1'b1;
      C_PRE: begin
        if (flag10) open_d = '0;
        else        open_d[ba] = 1'b0;
      end
      C_RD, C_WR: if (flag10) open_d[ba] = 1'b0;
      default: ;
    endcase
  end

  always_comb begin
    st_d = st_q;
    if (awake) begin
      if (!cke) begin
        if (exec == C_SREF)   st_d = P_SR;
        else if (|open_q)     st_d = P_APD;
        else                  st_d = P_PPD;
      end
    end else if (cke) begin
      st_d = P_AWAKE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q           <= P_AWAKE;
      open_q         <= '0;
      cmd_o          <= C_NOP;
      bank_o         <= '0;
      row_o          <= '0;
      col_o          <= '0;
      auto_pre_o     <= 1'b0;
      wr_en_o        <= '0;
      mode_reg_o     <= '0;
      ext_mode_reg_o <= '0;
      act_err_o      <= 1'b0;
      proto_err_o    <= 1'b0;
    end else begin
      st_q        <= st_d;
      open_q      <= open_d;
      cmd_o       <= exec;
      act_err_o   <= act_err_d;
      proto_err_o <= proto_d;
      auto_pre_o  <= (exec == C_RD || exec == C_WR) && flag10;
      wr_en_o     <= (exec == C_WR) ? ~dm : '0;
      if (exec == C_ACT || exec == C_PRE || exec == C_RD || exec == C_WR)
        bank_o <= ba;
      if (exec == C_ACT)
        row_o <= addr;
      if (exec == C_RD || exec == C_WR)
        col_o <= addr[COL_W-1:0];
      if (exec == C_MRS && ba == BANK_W'(0))
        mode_reg_o <= addr;
      if (exec == C_MRS && ba == BANK_W'(1))
        ext_mode_reg_o <= addr;
    end
  end

  assign open_mask_o = open_q;
  assign pwr_state_o = (st_q == P_SR && cke) ? P_AWAKE : st_q;

endmodule

// File: rtl/sdram_cmd_decoder_chk.sv
module sdram_cmd_decoder_chk #(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int LANES  = 9
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cke,
  input logic                   cs_n,
  input logic                   ras_n,
  input logic                   cas_n,
  input logic                   we_n,
  input logic [ADDR_W-1:0]      addr,
  input logic [3:0]             cmd_o,
  input logic [(1<<BANK_W)-1:0] open_mask_o,
  input logic [1:0]             pwr_state_o,
  input logic [LANES-1:0]       wr_en_o,
  input logic [ADDR_W-1:0]      mode_reg_o,
  input logic                   act_err_o,
  input logic                   proto_err_o,
  input logic [1:0]             st_q
);

  a_r1_cs_masks: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cmd_o == 4'd0));

  a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(mode_reg_o));

  a_r5_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 2'd0 && cke && !cs_n && !ras_n && cas_n && !we_n && addr[10])
      |=> (open_mask_o == '0));

  a_r9_sr_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 2'd3 && cke) |-> (pwr_state_o == 2'd0));

  a_r10_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != 2'd0) |=> (cmd_o == 4'd0 && $stable(open_mask_o)));

  a_r11_wr_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != 4'd6) |-> (wr_en_o == '0));

  a_r12_err_on_act: assert property (@(posedge clk) disable iff (!rst_n)
    act_err_o |-> (cmd_o == 4'd5));

  a_r13_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |-> (cmd_o == 4'd0));

endmodule

bind sdram_cmd_decoder sdram_cmd_decoder_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .LANES(LANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .addr(addr), .cmd_o(cmd_o),
  .open_mask_o(open_mask_o), .pwr_state_o(pwr_state_o), .wr_en_o(wr_en_o),
  .mode_reg_o(mode_reg_o), .act_err_o(act_err_o), .proto_err_o(proto_err_o),
  .st_q(st_q)
);

// File: tb/sdram_cmd_decoder_tb.sv
module sdram_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 39;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [8:0]  dm = '0;
  logic [3:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [12:0] row_o;
  logic [9:0]  col_o;
  logic        auto_pre_o;
  logic [3:0]  open_mask_o;
  logic [1:0]  pwr_state_o;
  logic [8:0]  wr_en_o;
  logic [12:0] mode_reg_o, ext_mode_reg_o;
  logic        act_err_o, proto_err_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dm(dm),
    .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
    .auto_pre_o(auto_pre_o), .open_mask_o(open_mask_o),
    .pwr_state_o(pwr_state_o), .wr_en_o(wr_en_o), .mode_reg_o(mode_reg_o),
    .ext_mode_reg_o(ext_mode_reg_o), .act_err_o(act_err_o),
    .proto_err_o(proto_err_o)
  );

  // {cke, cs_n, ras/cas/we, ba, addr, dm, exp cmd, exp open mask, exp power}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1,1'b1,3'b000,2'd0,13'h0000,9'h000,4'd0,4'b0000,2'd0}, // R1
    {1'b1,1'b0,3'b011,2'd1,13'h0123,9'h000,4'd5,4'b0010,2'd0}, // R3
    {1'b1,1'b0,3'b011,2'd2,13'h0456,9'h000,4'd5,4'b0110,2'd0}, // R3
    {1'b1,1'b0,3'b100,2'd1,13'h0005,9'h0F0,4'd6,4'b0110,2'd0}, // R2
    {1'b1,1'b0,3'b101,2'd2,13'h0407,9'h000,4'd7,4'b0010,2'd0}, // R4
    {1'b1,1'b0,3'b110,2'd0,13'h0000,9'h000,4'd8,4'b0010,2'd0}, // R2
    {1'b1,1'b0,3'b001,2'd0,13'h0000,9'h000,4'd2,4'b0010,2'd0}, // R2
    {1'b1,1'b0,3'b010,2'd1,13'h0000,9'h000,4'd4,4'b0000,2'd0}, // R5
    {1'b1,1'b0,3'b000,2'd0,13'h0031,9'h000,4'd1,4'b0000,2'd0}, // R6
    {1'b1,1'b0,3'b111,2'd0,13'h0000,9'h000,4'd0,4'b0000,2'd0}  // R2
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic k, input logic s, input logic [2:0] rcw,
                       input logic [1:0] b, input logic [12:0] a, input logic [8:0] m);
    cke = k; cs_n = s; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a; dm = m;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14 reset state
    chk("R14", "cmd", cmd_o, 0);
    chk("R14", "open", open_mask_o, 0);
    chk("R14", "pwr", pwr_state_o, 0);
    chk("R14", "mode", mode_reg_o, 0);
    chk("R14", "ext", ext_mode_reg_o, 0);
    chk("R14", "wr_en", wr_en_o, 0);
    chk("R14", "errs", {act_err_o, proto_err_o, auto_pre_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      drive(v[38], v[37], v[36:34], v[33:32], v[31:19], v[18:10]);
      step();
      chk($sformatf("R2 vec%0d", i), "cmd", cmd_o, v[9:6]);
      chk($sformatf("R3/R5 vec%0d", i), "open", open_mask_o, v[5:2]);
      chk($sformatf("R7 vec%0d", i), "pwr", pwr_state_o, v[1:0]);
    end
    chk("R6", "mode base", mode_reg_o, 13'h0031);

    // R6 extended and unused selects
    drive(1, 0, 3'b000, 2'd1, 13'h0044, 0); step();
    chk("R6", "ext", ext_mode_reg_o, 13'h0044);
    chk("R6", "mode kept", mode_reg_o, 13'h0031);
    drive(1, 0, 3'b000, 2'd2, 13'h1FFF, 0); step();
    chk("R6", "ba2 mode", mode_reg_o, 13'h0031);
    chk("R6", "ba2 ext", ext_mode_reg_o, 13'h0044);

    // R1 masked ACTIVE pattern
    drive(1, 1, 3'b011, 2'd0, 13'h0077, 0); step();
    chk("R1", "masked open", open_mask_o, 0);
    chk("R1", "masked cmd", cmd_o, 0);

    // R3 row and bank
    drive(1, 0, 3'b011, 2'd3, 13'h1ABC, 0); step();
    chk("R3", "row", row_o, 13'h1ABC);
    chk("R3", "bank", bank_o, 3);
    chk("R3", "open", open_mask_o, 4'b1000);
    chk("R12", "no err first act", act_err_o, 0);

    // R12 double ACTIVE
    drive(1, 0, 3'b011, 2'd3, 13'h0001, 0); step();
    chk("R12", "act_err", act_err_o, 1);
    chk("R12", "still open", open_mask_o, 4'b1000);
    drive(1, 0, 3'b111, 2'd0, 0, 0); step();
    chk("R12", "act_err drop", act_err_o, 0);

    // R4 / R11 write with auto-precharge
    drive(1, 0, 3'b100, 2'd3, 13'h06A5, 9'h0A5); step();
    chk("R4", "col", col_o, 10'h2A5);
    chk("R4", "auto_pre", auto_pre_o, 1);
    chk("R4", "closed", open_mask_o, 0);
    chk("R11", "wr_en", wr_en_o, 9'h15A);
    drive(1, 0, 3'b101, 2'd3, 13'h0011, 9'h000); step();
    chk("R11", "read wr_en", wr_en_o, 0);
    chk("R4", "auto_pre low", auto_pre_o, 0);
    chk("R4", "read col", col_o, 10'h011);

    // R7 active power-down, R10 ignore, R9 exit
    drive(1, 0, 3'b011, 2'd0, 13'h0002, 0); step();
    drive(0, 1, 3'b111, 2'd0, 0, 0); step();
    chk("R7", "apd", pwr_state_o, 2);
    drive(0, 0, 3'b010, 2'd0, 13'h0400, 0); step();
    chk("R10", "pre ignored open", open_mask_o, 4'b0001);
    chk("R10", "pre ignored cmd", cmd_o, 0);
    drive(1, 0, 3'b010, 2'd0, 13'h0400, 0); step();
    chk("R9", "pd exit", pwr_state_o, 0);
    chk("R10", "exit edge ignored", open_mask_o, 4'b0001);

    // R5 precharge all, R7 precharge power-down
    drive(1, 0, 3'b010, 2'd2, 13'h0400, 0); step();
    chk("R5", "pre all", open_mask_o, 0);
    drive(0, 1, 3'b111, 2'd0, 0, 0); step();
    chk("R7", "ppd", pwr_state_o, 1);
    drive(1, 1, 3'b111, 2'd0, 0, 0); step();
    chk("R9", "ppd exit", pwr_state_o, 0);

    // R13 read with clock enable low
    drive(1, 0, 3'b011, 2'd0, 13'h0003, 0); step();
    drive(0, 0, 3'b101, 2'd0, 13'h0400, 0); step();
    chk("R13", "proto_err", proto_err_o, 1);
    chk("R13", "cmd", cmd_o, 0);
    chk("R13", "open kept", open_mask_o, 4'b0001);
    chk("R13", "apd", pwr_state_o, 2);
    drive(1, 1, 3'b111, 2'd0, 0, 0); step();
    chk("R13", "proto drop", proto_err_o, 0);
    chk("R9", "exit", pwr_state_o, 0);

    // R8 self refresh, R9 asynchronous release
    drive(1, 0, 3'b010, 2'd0, 13'h0400, 0); step();
    drive(0, 0, 3'b001, 2'd0, 0, 0); step();
    chk("R8", "cmd sref", cmd_o, 3);
    chk("R8", "pwr sr", pwr_state_o, 3);
    drive(0, 1, 3'b111, 2'd0, 0, 0); step();
    chk("R8", "stay sr", pwr_state_o, 3);
    #1 cke = 1'b1;
    #1 chk("R9", "sr async release", pwr_state_o, 0);
    step();
    chk("R9", "sr registered exit", pwr_state_o, 0);
    chk("R10", "sr exit cmd", cmd_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule